// File: doc/BRIEF.md
# Four-line console transmit/receive selector

This block puts four logical serial lines behind one register-level console interface. The lines are the console terminal (ID 0), remote services (ID 1), the environmental monitor (ID 2) and the logical console (ID 3). Transmit uses one shared ready flag. A fixed-priority choice is made over the lines that software has enabled and that are idle. The ID of the chosen line appears in a read-only field of the transmit status word. The next transmit data write is sent to that line.

Each line has a valid/ready port on both sides. On the transmit side, a line asserts valid and holds its character until the far end takes it. On the receive side, the block takes one character at a time from the highest-numbered line that offers one. It tags that character with its source line and holds it until software reads it.

Software reaches the block through a single-cycle register port with four word addresses. Reads have no latency. The only read with a side effect is the receive data read, which consumes the held character.

Top module: `console_line_mux`

## Requirements
- R1: After reset, the transmit status word reads 0x0001_0080. This means only line 0 is enabled, the selected ID is 0, done is set and interrupt enable is clear. No line asserts tx_valid, both interrupts are low and the receive status word reads 0.
- R2: Register addresses are 0 for transmit status, 1 for transmit data, 2 for receive status and 3 for receive data. A write to transmit status changes only the enable mask (bits 19:16, one bit per line ID) and interrupt enable (bit 6). Done (bit 7) and the ID field (bits 11:8) ignore the written value, and bit 15 always reads 0.
- R3: The selected ID (bits 11:8) is the highest line ID that is both enabled and idle. It is 0xF when no line qualifies.
- R4: Selection is re-run when any line completes a transfer, and when a transmit status write has bit 15 set. Each selection sets done and raises tx_irq if interrupt enable is set.
- R5: A transmit data write while the ID is 0..3 clears done and tx_irq. It latches bits 7:0 of the write data into that line and makes the line busy. A write while the ID is 0xF changes nothing.
- R6: A transmit status write with bit 6 clear drops tx_irq. A write with bit 6 set while done is set raises tx_irq immediately.
- R7: A busy line keeps tx_valid high with a stable character until tx_ready is seen. From the next cycle on, the line counts as idle.
- R8: A received character is taken only while receive done (receive status bit 7) is clear. The block takes it from the highest-ID line whose rx_valid is high. Taking it sets receive done and raises rx_irq if receive interrupt enable (bit 6) is set.
- R9: A receive data read returns the character in bits 7:0, the source ID in bits 11:8 and 1101b in bits 19:16, with all other bits zero. The read clears receive done and rx_irq.
- R10: Only bit 6 of a receive status write takes effect. Writing it 0 drops rx_irq, and writing it 1 while receive done is set raises rx_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (receive data read consumes the character) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from state |
| tx_valid | output | NLINES | Per-line transmit valid |
| tx_data | output | NLINES*CHAR_W | Per-line transmit character, line i at bits i*CHAR_W |
| tx_ready | input | NLINES | Per-line transmit accept |
| rx_valid | input | NLINES | Per-line receive character offered |
| rx_data | input | NLINES*CHAR_W | Per-line receive character |
| rx_ready | output | NLINES | Per-line receive accept, at most one high |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The assertions assume that reg_wr and reg_rd are never high in the same cycle. They also assume that a receiving line keeps rx_valid and its character steady until it sees rx_ready, and then drops the character it handed over. The bench drives the register port one access per cycle, on the falling edge. It removes an offered receive character in the cycle right after acceptance. It pulses tx_ready for single cycles so that completions land on known edges and do not overlap register writes. That leaves only the ordering of a completion against a data write, which the assertions cover.

// File: rtl/console_line_mux_pkg.sv
// Package: register addresses and field positions shared by the selector,
// its sub-blocks and its checker. Assumes a word of at least 20 bits.
package console_line_mux_pkg;
    typedef enum logic [1:0] {
        ADDR_TXCS = 2'd0,
        ADDR_TXDB = 2'd1,
        ADDR_RXCS = 2'd2,
        ADDR_RXDB = 2'd3
    } reg_sel_e;

    localparam int          ID_W      = 4;
    localparam int          BIT_DONE  = 7;
    localparam int          BIT_IE    = 6;
    localparam int          BIT_RESEL = 15;
    localparam int          ID_LSB    = 8;
    localparam int          MASK_LSB  = 16;
    localparam logic [3:0]  ID_NONE   = 4'hF;
    localparam logic [3:0]  CARRIER   = 4'b1101;
endpackage

// File: rtl/cons_prio_pick.sv
// Fixed-priority picker: reports whether any request is high and the index
// of the highest-numbered one. Purely combinational; assumes N <= 2**IW.
module cons_prio_pick #(
    parameter int N  = 4,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // Scan upward so a later (higher) index overrides a lower one.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/cons_tx_lane.sv
// One transmit line: holds a character and presents it as valid until the
// far end accepts it. Assumes load is only asserted for the selected line.
module cons_tx_lane #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_char,
    input  logic          tx_ready,
    output logic          tx_valid,
    output logic [CW-1:0] tx_data,
    output logic          xfer,
    output logic          idle_next
);
    logic          busy;
    logic [CW-1:0] hold;

    assign xfer      = busy & tx_ready;
    assign idle_next = !load && !(busy && !tx_ready);
    assign tx_valid  = busy;
    assign tx_data   = hold;

    // Busy/character register: load wins over a completion in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            hold <= '0;
        end else if (load) begin
            busy <= 1'b1;
            hold <= load_char;
        end else if (xfer) begin
            busy <= 1'b0;
        end
    end
endmodule

// File: rtl/cons_rx_path.sv
// Receive side: takes one character from the highest-ID offering line while
// no character is held, tags it with the source ID and manages receive done,
// enable and interrupt. Assumes lines hold rx_valid until rx_ready.
module cons_rx_path #(
    parameter int N  = 4,
    parameter int CW = 8,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  rx_valid,
    input  logic [N*CW-1:0] rx_data,
    output logic [N-1:0]  rx_ready,
    input  logic          csr_wr,
    input  logic          ie_wdata,
    input  logic          db_rd,
    output logic          done,
    output logic          ie,
    output logic          irq,
    output logic [CW-1:0] char_q,
    output logic [IW-1:0] src_q
);
    logic          hit;
    logic [IW-1:0] idx;
    logic          accept;
    logic          ie_n, done_n, irq_n;

    cons_prio_pick #(.N(N), .IW(IW)) u_pick (
        .req (rx_valid),
        .hit (hit),
        .idx (idx)
    );

    assign accept = hit && !done;

    // Accept strobe toward the winning line only.
    always_comb begin
        rx_ready = '0;
        if (accept) rx_ready[idx] = 1'b1;
    end

    // Next-state of enable, done and interrupt in software-visible order.
    always_comb begin
        ie_n   = csr_wr ? ie_wdata : ie;
        done_n = done;
        irq_n  = irq;
        if (db_rd) begin
            done_n = 1'b0;
            irq_n  = 1'b0;
        end
        if (accept) begin
            done_n = 1'b1;
            if (ie_n) irq_n = 1'b1;
        end
        if (csr_wr) begin
            if (!ie_n)       irq_n = 1'b0;
            else if (done_n) irq_n = 1'b1;
        end
    end

    // State registers and captured character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            ie     <= 1'b0;
            irq    <= 1'b0;
            char_q <= '0;
            src_q  <= '0;
        end else begin
            done <= done_n;
            ie   <= ie_n;
            irq  <= irq_n;
            if (accept) begin
                char_q <= rx_data[idx*CW +: CW];
                src_q  <= idx;
            end
        end
    end
endmodule

// File: rtl/console_line_mux.sv
// Top: four-line console selector. Transmit status holds the per-line enable
// mask and interrupt enable; a priority choice over enabled, idle lines is
// published as the selected ID and steers the next data write. Assumes one
// register access per cycle and NLINES <= 4 (ID field of four bits).
module console_line_mux
    import console_line_mux_pkg::*;
#(
    parameter int NLINES = 4,
    parameter int CHAR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic                     reg_rd,
    input  logic [1:0]               reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    output logic [NLINES-1:0]        tx_valid,
    output logic [NLINES*CHAR_W-1:0] tx_data,
    input  logic [NLINES-1:0]        tx_ready,
    input  logic [NLINES-1:0]        rx_valid,
    input  logic [NLINES*CHAR_W-1:0] rx_data,
    output logic [NLINES-1:0]        rx_ready,
    output logic                     tx_irq,
    output logic                     rx_irq
);
    localparam logic [NLINES-1:0] EN_RESET = NLINES'(1);

    logic [NLINES-1:0] tx_en;
    logic              tx_ie, tx_done;
    logic [ID_W-1:0]   tx_id;

    logic              csr_wr, dat_wr, rxcs_wr, rxdb_rd;
    logic              id_valid, reselect, pick_hit;
    logic [ID_W-1:0]   pick_idx;
    logic [NLINES-1:0] lane_load, lane_xfer, lane_idle_next;
    logic [NLINES-1:0] en_n;
    logic              ie_n, done_n, irq_n;
    logic [ID_W-1:0]   id_n;

    logic              rx_done, rx_ie;
    logic [CHAR_W-1:0] rx_char;
    logic [ID_W-1:0]   rx_src;

    assign csr_wr   = reg_wr && (reg_addr == ADDR_TXCS);
    assign dat_wr   = reg_wr && (reg_addr == ADDR_TXDB);
    assign rxcs_wr  = reg_wr && (reg_addr == ADDR_RXCS);
    assign rxdb_rd  = reg_rd && (reg_addr == ADDR_RXDB);
    assign id_valid = (tx_id < ID_W'(NLINES));

    // One transmit lane per line; the load goes to the selected ID only.
    for (genvar g = 0; g < NLINES; g++) begin : g_lane
        assign lane_load[g] = dat_wr && id_valid && (tx_id == ID_W'(g));
        cons_tx_lane #(.CW(CHAR_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (lane_load[g]),
            .load_char (reg_wdata[CHAR_W-1:0]),
            .tx_ready  (tx_ready[g]),
            .tx_valid  (tx_valid[g]),
            .tx_data   (tx_data[g*CHAR_W +: CHAR_W]),
            .xfer      (lane_xfer[g]),
            .idle_next (lane_idle_next[g])
        );
    end

    assign en_n     = csr_wr ? reg_wdata[MASK_LSB +: NLINES] : tx_en;
    assign ie_n     = csr_wr ? reg_wdata[BIT_IE] : tx_ie;
    assign reselect = (|lane_xfer) || (csr_wr && reg_wdata[BIT_RESEL]);

    cons_prio_pick #(.N(NLINES), .IW(ID_W)) u_tx_pick (
        .req (en_n & lane_idle_next),
        .hit (pick_hit),
        .idx (pick_idx)
    );

    // Transmit next state: data write first, then reselection, then CSR IE rule.
    always_comb begin
        id_n   = tx_id;
        done_n = tx_done;
        irq_n  = tx_irq;
        if (dat_wr && id_valid) begin
            done_n = 1'b0;
            irq_n  = 1'b0;
        end
        if (reselect) begin
            id_n   = pick_hit ? pick_idx : ID_NONE;
            done_n = 1'b1;
            if (ie_n) irq_n = 1'b1;
        end
        if (csr_wr) begin
            if (!ie_n)       irq_n = 1'b0;
            else if (done_n) irq_n = 1'b1;
        end
    end

    // Transmit status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en   <= EN_RESET;
            tx_ie   <= 1'b0;
            tx_done <= 1'b1;
            tx_irq  <= 1'b0;
            tx_id   <= '0;
        end else begin
            tx_en   <= en_n;
            tx_ie   <= ie_n;
            tx_done <= done_n;
            tx_irq  <= irq_n;
            tx_id   <= id_n;
        end
    end

    cons_rx_path #(.N(NLINES), .CW(CHAR_W), .IW(ID_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_ready (rx_ready),
        .csr_wr   (rxcs_wr),
        .ie_wdata (reg_wdata[BIT_IE]),
        .db_rd    (rxdb_rd),
        .done     (rx_done),
        .ie       (rx_ie),
        .irq      (rx_irq),
        .char_q   (rx_char),
        .src_q    (rx_src)
    );

    // Read data multiplexer, combinational from state.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_TXCS: begin
                reg_rdata[MASK_LSB +: NLINES] = tx_en;
                reg_rdata[ID_LSB +: ID_W]     = tx_id;
                reg_rdata[BIT_DONE]           = tx_done;
                reg_rdata[BIT_IE]             = tx_ie;
            end
            ADDR_RXCS: begin
                reg_rdata[BIT_DONE] = rx_done;
                reg_rdata[BIT_IE]   = rx_ie;
            end
            ADDR_RXDB: begin
                reg_rdata[MASK_LSB +: 4]  = CARRIER;
                reg_rdata[ID_LSB +: ID_W] = rx_src;
                reg_rdata[CHAR_W-1:0]     = rx_char;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/console_line_mux_chk.sv
// Checker: temporal properties of the selector, bound into the top module.
// Assumes the register port never reads and writes in the same cycle.
module console_line_mux_chk
    import console_line_mux_pkg::*;
#(
    parameter int NLINES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [1:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [NLINES-1:0] tx_valid,
    input logic [NLINES-1:0] tx_ready,
    input logic [NLINES-1:0] rx_ready,
    input logic              tx_done,
    input logic              tx_ie,
    input logic              tx_irq,
    input logic [3:0]        tx_id,
    input logic              rx_done,
    input logic              rx_irq
);
    assert_tx_id_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_id < 4'(NLINES)) || (tx_id == ID_NONE));

    assert_irq_needs_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> (tx_done && tx_ie));

    assert_ie_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_TXCS && !reg_wdata[BIT_IE]) |=> !tx_irq);

    assert_complete_sets_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(tx_valid & tx_ready)) |=> tx_done);

    assert_data_write_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_TXDB && tx_id != ID_NONE && !(|(tx_valid & tx_ready)))
        |=> (!tx_done && !tx_irq));

    assert_valid_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(tx_valid & ~tx_ready) & ~tx_valid) == '0));

    assert_rx_one_taker_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_ready) && ((|rx_ready) -> !rx_done));

    assert_rx_take_sets_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|rx_ready) |=> rx_done);

    assert_rx_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_RXDB && rx_done) |=> (!rx_done && !rx_irq));
endmodule

bind console_line_mux console_line_mux_chk #(.NLINES(NLINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (32'(reg_wdata)),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .rx_ready  (rx_ready),
    .tx_done   (tx_done),
    .tx_ie     (tx_ie),
    .tx_irq    (tx_irq),
    .tx_id     (tx_id),
    .rx_done   (rx_done),
    .rx_irq    (rx_irq)
);

// File: tb/console_line_mux_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module console_line_mux_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  tx_valid;
    logic [31:0] tx_data;
    logic [3:0]  tx_ready = '0;
    logic [3:0]  rx_valid = '0;
    logic [7:0]  rx_char [4];
    logic [31:0] rx_data;
    logic [3:0]  rx_ready;
    logic        tx_irq, rx_irq;

    int checks = 0;
    int errors = 0;
    logic done_flag = 1'b0;

    assign rx_data = {rx_char[3], rx_char[2], rx_char[1], rx_char[0]};

    always #4 clk = ~clk;

    console_line_mux u_console_line_mux (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(2'd0, v);
        chk("R1 txcs", v, 32'h0001_0080);
        chk("R1 tx_valid", 32'(tx_valid), 32'h0);
        chk("R1 irqs", {30'd0, tx_irq, rx_irq}, 32'h0);
        rd(2'd2, v);
        chk("R1 rxcs", v, 32'h0);
    endtask

    task automatic t_csr_fields;
        logic [31:0] v;
        wr(2'd0, 32'hFFFA_7F7F);
        rd(2'd0, v);
        chk("R2 only mask and ie written", v, 32'h000A_00C0);
        chk("R6 ie set while done raises irq", 32'(tx_irq), 32'h1);
        wr(2'd0, 32'h000A_0000);
        chk("R6 ie clear drops irq", 32'(tx_irq), 32'h0);
    endtask

    task automatic t_priority;
        logic [31:0] v;
        wr(2'd0, 32'h000F_8000);
        rd(2'd0, v); chk("R3 all enabled picks 3", v, 32'h000F_0380);
        wr(2'd0, 32'h0005_8000);
        rd(2'd0, v); chk("R3 mask 0101 picks 2", v, 32'h0005_0280);
        wr(2'd0, 32'h0002_8000);
        rd(2'd0, v); chk("R3 mask 0010 picks 1", v, 32'h0002_0180);
        wr(2'd0, 32'h0001_8000);
        rd(2'd0, v); chk("R3 mask 0001 picks 0", v, 32'h0001_0080);
        wr(2'd0, 32'h0000_8000);
        rd(2'd0, v); chk("R3 none gives F", v, 32'h0000_0F80);
    endtask

    task automatic t_transmit;
        logic [31:0] v;
        wr(2'd0, 32'h000F_8040);
        chk("R4 reselect with ie raises irq", 32'(tx_irq), 32'h1);
        wr(2'd1, 32'h0000_01A5);
        chk("R5 line 3 valid", 32'(tx_valid), 32'h8);
        chk("R5 low byte latched", 32'(tx_data[31:24]), 32'hA5);
        chk("R5 irq cleared", 32'(tx_irq), 32'h0);
        rd(2'd0, v); chk("R5 done cleared", v, 32'h000F_0340);
        wr(2'd0, 32'h000F_8040);
        rd(2'd0, v); chk("R3 busy line skipped", v, 32'h000F_02C0);
        wr(2'd1, 32'h0000_003C);
        chk("R5 line 2 loaded", 32'(tx_valid), 32'hC);
        repeat (3) @(negedge clk);
        chk("R7 held without ready", 32'(tx_valid), 32'hC);
        tx_ready = 4'b1000;
        @(posedge clk); @(negedge clk);
        tx_ready = 4'b0000;
        chk("R7 line 3 released", 32'(tx_valid), 32'h4);
        chk("R7 line 2 char stable", 32'(tx_data[23:16]), 32'h3C);
        chk("R4 completion irq", 32'(tx_irq), 32'h1);
        rd(2'd0, v); chk("R4 completion reselects 3", v, 32'h000F_03C0);
        wr(2'd1, 32'h0000_0077);
        chk("R7 line 3 reusable", 32'(tx_data[31:24]), 32'h77);
        tx_ready = 4'b1100;
        @(posedge clk); @(negedge clk);
        tx_ready = 4'b0000;
        chk("R7 both released", 32'(tx_valid), 32'h0);
    endtask

    task automatic t_ignored;
        logic [31:0] v;
        wr(2'd0, 32'h0000_8000);
        wr(2'd1, 32'h0000_0055);
        chk("R5 write with id F ignored", 32'(tx_valid), 32'h0);
        rd(2'd0, v); chk("R5 done kept with id F", v, 32'h0000_0F80);
    endtask

    task automatic t_receive;
        logic [31:0] v;
        wr(2'd2, 32'hFFFF_FF7F);
        rd(2'd2, v); chk("R10 only ie written", v, 32'h0000_0040);
        rx_char[0] = 8'h11; rx_char[2] = 8'h22;
        rx_valid = 4'b0101;
        #1 chk("R8 highest line offered", 32'(rx_ready), 32'h4);
        @(posedge clk); @(negedge clk);
        rx_valid = 4'b0001;
        #1 chk("R8 no take while done", 32'(rx_ready), 32'h0);
        chk("R8 irq on take", 32'(rx_irq), 32'h1);
        rd(2'd3, v); chk("R9 data format line 2", v, 32'h000D_0222);
        chk("R9 read clears irq", 32'(rx_irq), 32'h0);
        #1 chk("R8 next line offered", 32'(rx_ready), 32'h1);
        @(posedge clk); @(negedge clk);
        rx_valid = 4'b0000;
        rd(2'd3, v); chk("R9 data format line 0", v, 32'h000D_0011);
        rd(2'd2, v); chk("R9 done cleared", v, 32'h0000_0040);
        wr(2'd2, 32'h0);
        rx_char[3] = 8'h7E; rx_valid = 4'b1000;
        @(posedge clk); @(negedge clk);
        rx_valid = 4'b0000;
        chk("R8 no irq with ie clear", 32'(rx_irq), 32'h0);
        rd(2'd2, v); chk("R8 done set", v, 32'h0000_0080);
        wr(2'd2, 32'h0000_0040);
        chk("R10 ie set while done raises irq", 32'(rx_irq), 32'h1);
        wr(2'd2, 32'h0);
        chk("R10 ie clear drops irq", 32'(rx_irq), 32'h0);
        rd(2'd3, v); chk("R9 line 3 data", v, 32'h000D_037E);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) rx_char[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_csr_fields();
        t_priority();
        t_transmit();
        t_ignored();
        t_receive();
        done_flag = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule